// File: doc/BRIEF.md
# Z80 Paged Memory Mapper

This block sits between a Z80-style CPU and its memory. It divides the 64 KB logical space into sixteen 4 KB pages. Each page has a 7-bit register holding the number of a 4 KB block in a 512 KB physical space. The physical address is formed by replacing the top four logical address bits with the selected block number, which gives a 19-bit result. The translation is purely combinational.

Software loads a page register with an I/O write to port 0FEh. The port number is carried in the low address byte. The page index comes from the upper address nibble, which holds the B register of an `OUT (C),r` instruction. The data byte carries the block number.

The mapped address is also decoded into two selects. One enables the 256 KB onboard RAM. The other enables a 4 KB boot ROM that sits at physical 0F000h–0FFFFh. Both selects are qualified by the memory request strobe.

Top module: `z80_page_mapper`

## Requirements
- R1: After reset, page register n holds block number n (for n from 0 to 15), so logical addresses map one-to-one onto physical 00000h–0FFFFh.
- R2: At a rising clock edge with iorq_ni=0, wr_ni=0, m1_ni=1 and addr_i[7:0]=FEh, the page register indexed by addr_i[15:12] loads data_i[6:0].
- R3: Bit 7 of the written data byte is discarded and never affects the stored block number.
- R4: An I/O cycle to any port other than FEh has no effect on the page registers. So does an I/O cycle with m1_ni low, or one with wr_ni high. A memory cycle also leaves the registers unchanged.
- R5: paddr_o[18:12] equals the page register selected by addr_i[15:12], and paddr_o[11:0] equals addr_i[11:0]; both follow the inputs without a clock.
- R6: rom_sel_o is high exactly when mreq_ni=0 and paddr_o[18:12]=0Fh (physical 0F000h–0FFFFh).
- R7: ram_sel_o is high exactly when mreq_ni=0, paddr_o[18]=0 and rom_sel_o is low. The ROM window therefore overrides RAM, and physical blocks 40h–7Fh select neither device.
- R8: With mreq_ni high, both ram_sel_o and rom_sel_o are low, including during I/O cycles.
- R9: A register loaded at a clock edge shows up on paddr_o for that page from the same edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address bus |
| data_i | input | 8 | CPU data bus (write data) |
| iorq_ni | input | 1 | I/O request, active low |
| mreq_ni | input | 1 | Memory request, active low |
| wr_ni | input | 1 | Write strobe, active low |
| m1_ni | input | 1 | Opcode fetch / interrupt acknowledge, active low |
| paddr_o | output | 19 | Physical address |
| ram_sel_o | output | 1 | Onboard RAM select |
| rom_sel_o | output | 1 | Boot ROM select |

## Verification
Four properties are checked on every cycle: the selects stay silent outside memory requests, the ROM select occurs only at physical block 0Fh and takes priority over RAM, RAM is chosen exactly for the lower 256 KB outside that window, and the page offset passes straight through. A further property checks that a qualifying port write is visible on the next cycle's translation for that page. Only the bench scenarios can show the identity map after reset and that bit 7 is dropped. They also show that ignored I/O cycles change nothing, because the effect appears only when the affected page is later read through the address path.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [1:0] {
    REGION_NONE = 2'd0,
    REGION_RAM  = 2'd1,
    REGION_ROM  = 2'd2
  } region_e;
endpackage

// File: rtl/z80_io_decode.sv
module z80_io_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned PORT_W   = 8,
  parameter logic [7:0]  MAP_PORT = 8'hFE
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              iorq_ni,
  input  logic              wr_ni,
  input  logic              m1_ni,
  output logic              we_o
);
  // M1 with IORQ is an interrupt acknowledge, never a port write
  always_comb begin
    we_o = !iorq_ni && !wr_ni && m1_ni && (addr_i[PORT_W-1:0] == MAP_PORT[PORT_W-1:0]);
  end
endmodule

// File: rtl/z80_map_regs.sv
module z80_map_regs #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned BLK_W = 7,
  localparam int unsigned NREG = 1 << IDX_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [BLK_W-1:0]           blk_i,
  output logic [NREG-1:0][BLK_W-1:0] map_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        map_o[g] <= BLK_W'(g);  // identity map out of reset
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        map_o[g] <= blk_i;
      end
    end
  end
endmodule

// File: rtl/z80_page_xlate.sv
module z80_page_xlate #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned BLK_W  = 7,
  localparam int unsigned OFS_W  = ADDR_W - IDX_W,
  localparam int unsigned PHYS_W = BLK_W + OFS_W,
  localparam int unsigned NREG   = 1 << IDX_W
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NREG-1:0][BLK_W-1:0] map_i,
  output logic [PHYS_W-1:0]          paddr_o
);
  logic [IDX_W-1:0] page;

  always_comb begin
    page    = addr_i[ADDR_W-1 -: IDX_W];
    paddr_o = {map_i[page], addr_i[OFS_W-1:0]};
  end
endmodule

// File: rtl/z80_mem_decode.sv
module z80_mem_decode
  import mmu_pkg::*;
#(
  parameter int unsigned PHYS_W  = 19,
  parameter int unsigned OFS_W   = 12,
  parameter int unsigned RAM_AW  = 18,
  parameter logic [6:0]  ROM_BLK = 7'h0F,
  localparam int unsigned BLK_W  = PHYS_W - OFS_W
) (
  input  logic [PHYS_W-1:0] paddr_i,
  input  logic              mreq_ni,
  output logic              ram_sel_o,
  output logic              rom_sel_o
);
  region_e region;

  always_comb begin
    region = REGION_NONE;
    if (!mreq_ni) begin
      // ROM window is checked first: it lies inside the RAM range
      if (paddr_i[PHYS_W-1:OFS_W] == ROM_BLK[BLK_W-1:0]) begin
        region = REGION_ROM;
      end else if (paddr_i[PHYS_W-1:RAM_AW] == '0) begin
        region = REGION_RAM;
      end
    end
    ram_sel_o = (region == REGION_RAM);
    rom_sel_o = (region == REGION_ROM);
  end
endmodule

// File: rtl/z80_page_mapper.sv
module z80_page_mapper #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned BLK_W    = 7,
  parameter int unsigned RAM_AW   = 18,
  parameter logic [7:0]  MAP_PORT = 8'hFE,
  parameter logic [6:0]  ROM_BLK  = 7'h0F,
  localparam int unsigned OFS_W   = ADDR_W - IDX_W,
  localparam int unsigned PHYS_W  = BLK_W + OFS_W,
  localparam int unsigned NREG    = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              iorq_ni,
  input  logic              mreq_ni,
  input  logic              wr_ni,
  input  logic              m1_ni,
  output logic [PHYS_W-1:0] paddr_o,
  output logic              ram_sel_o,
  output logic              rom_sel_o
);
  logic                       map_we;
  logic [NREG-1:0][BLK_W-1:0] map;

  z80_io_decode #(
    .ADDR_W  (ADDR_W),
    .PORT_W  (8),
    .MAP_PORT(MAP_PORT)
  ) u_io_dec (
    .addr_i (addr_i),
    .iorq_ni(iorq_ni),
    .wr_ni  (wr_ni),
    .m1_ni  (m1_ni),
    .we_o   (map_we)
  );

  // page index rides on the upper address byte during the port write
  z80_map_regs #(
    .IDX_W(IDX_W),
    .BLK_W(BLK_W)
  ) u_regs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (map_we),
    .idx_i (addr_i[ADDR_W-1 -: IDX_W]),
    .blk_i (data_i[BLK_W-1:0]),
    .map_o (map)
  );

  z80_page_xlate #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .BLK_W (BLK_W)
  ) u_xlate (
    .addr_i (addr_i),
    .map_i  (map),
    .paddr_o(paddr_o)
  );

  z80_mem_decode #(
    .PHYS_W (PHYS_W),
    .OFS_W  (OFS_W),
    .RAM_AW (RAM_AW),
    .ROM_BLK(ROM_BLK)
  ) u_mdec (
    .paddr_i  (paddr_o),
    .mreq_ni  (mreq_ni),
    .ram_sel_o(ram_sel_o),
    .rom_sel_o(rom_sel_o)
  );
endmodule

// File: rtl/z80_page_mapper_chk.sv
module z80_page_mapper_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic [7:0]  data_i,
  input logic        iorq_ni,
  input logic        mreq_ni,
  input logic        wr_ni,
  input logic        m1_ni,
  input logic [18:0] paddr_o,
  input logic        ram_sel_o,
  input logic        rom_sel_o
);
  logic port_wr;
  assign port_wr = !iorq_ni && !wr_ni && m1_ni && (addr_i[7:0] == 8'hFE);

  assert_rom_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_sel_o |-> (!mreq_ni && paddr_o[18:12] == 7'h0F));

  assert_rom_over_ram_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_sel_o |-> (!paddr_o[18] && !rom_sel_o));

  assert_ram_cover_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_ni && !paddr_o[18]) |-> (ram_sel_o || rom_sel_o));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_ni |-> (!ram_sel_o && !rom_sel_o));

  assert_offset_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paddr_o[11:0] == addr_i[11:0]);

  assert_write_seen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(port_wr) && addr_i[15:12] == $past(addr_i[15:12]))
      |-> (paddr_o[18:12] == $past(data_i[6:0])));
endmodule

bind z80_page_mapper z80_page_mapper_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .data_i   (data_i),
  .iorq_ni  (iorq_ni),
  .mreq_ni  (mreq_ni),
  .wr_ni    (wr_ni),
  .m1_ni    (m1_ni),
  .paddr_o  (paddr_o),
  .ram_sel_o(ram_sel_o),
  .rom_sel_o(rom_sel_o)
);

// File: tb/sim_z80_page_mapper.sv
`timescale 1ns/1ps
module sim_z80_page_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        iorq_n = 1'b1, mreq_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic [18:0] paddr;
  logic        ram_sel, rom_sel;

  int n_chk = 0, n_fail = 0;
  logic [6:0] model [16];

  always #2.5 clk = ~clk;

  z80_page_mapper u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data),
    .iorq_ni(iorq_n), .mreq_ni(mreq_n), .wr_ni(wr_n), .m1_ni(m1_n),
    .paddr_o(paddr), .ram_sel_o(ram_sel), .rom_sel_o(rom_sel)
  );

  function automatic logic [18:0] exp_paddr(input logic [15:0] a);
    return {model[a[15:12]], a[11:0]};
  endfunction

  function automatic logic exp_rom(input logic [15:0] a, input logic mq_n);
    return !mq_n && (model[a[15:12]] == 7'h0F);
  endfunction

  function automatic logic exp_ram(input logic [15:0] a, input logic mq_n);
    return !mq_n && !model[a[15:12]][6] && (model[a[15:12]] != 7'h0F);
  endfunction

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one I/O cycle; model updates only when the write qualifies
  task automatic io_cycle(input logic [3:0] idx, input logic [7:0] port,
                          input logic [7:0] d, input logic m1v, input logic wrv,
                          input logic iorqv);
    @(negedge clk);
    mreq_n = 1'b1; iorq_n = iorqv; wr_n = wrv; m1_n = m1v;
    addr = {idx, 4'h0, port}; data = d;
    @(negedge clk);
    if (!iorqv && !wrv && m1v && port == 8'hFE) model[idx] = d[6:0];
    iorq_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
  endtask

  task automatic mem_access(input string req, input logic [15:0] a, input logic mq_n);
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1; mreq_n = mq_n; addr = a; data = $urandom;
    #1;
    check(req, {2'b0, paddr}, {2'b0, exp_paddr(a)});
    check(req, {19'b0, rom_sel, ram_sel}, {19'b0, exp_rom(a, mq_n), exp_ram(a, mq_n)});
  endtask

  initial begin
    #5000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) model[i] = 7'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: identity map, incl. ROM at logical F000
    for (int i = 0; i < 16; i++) mem_access("R1", {4'(i), 12'(i * 37)}, 1'b0);
    mem_access("R6", 16'hF123, 1'b0);
    mem_access("R8", 16'hF123, 1'b1);

    // R3: bit 7 discarded
    io_cycle(4'h2, 8'hFE, 8'hC5, 1'b1, 1'b0, 1'b0);
    mem_access("R3", 16'h2ABC, 1'b0);

    // R4: non-qualifying cycles change nothing
    io_cycle(4'h2, 8'hFD, 8'h11, 1'b1, 1'b0, 1'b0);
    io_cycle(4'h2, 8'hFE, 8'h12, 1'b0, 1'b0, 1'b0);
    io_cycle(4'h2, 8'hFE, 8'h13, 1'b1, 1'b1, 1'b0);
    io_cycle(4'h2, 8'hFE, 8'h14, 1'b1, 1'b0, 1'b1);
    mem_access("R4", 16'h2001, 1'b0);
    check("R4", {14'b0, paddr[18:12]}, {14'b0, 7'h45});

    // R7: ROM window moved away, RAM takes over
    io_cycle(4'hF, 8'hFE, 8'h10, 1'b1, 1'b0, 1'b0);
    mem_access("R7", 16'hF000, 1'b0);
    // R6: another page landing on block 0F selects ROM
    io_cycle(4'h3, 8'hFE, 8'h0F, 1'b1, 1'b0, 1'b0);
    mem_access("R6", 16'h3ABC, 1'b0);
    // R7: boundary 3F vs 40
    io_cycle(4'h4, 8'hFE, 8'h3F, 1'b1, 1'b0, 1'b0);
    mem_access("R7", 16'h4FFF, 1'b0);
    io_cycle(4'h5, 8'hFE, 8'h40, 1'b1, 1'b0, 1'b0);
    mem_access("R7", 16'h5000, 1'b0);
    io_cycle(4'h6, 8'hFE, 8'h7F, 1'b1, 1'b0, 1'b0);
    mem_access("R7", 16'h6FFF, 1'b0);
    mem_access("R8", 16'h6FFF, 1'b1);

    // R2/R5/R9: remap every register, then random mix
    for (int i = 0; i < 16; i++) begin
      io_cycle(4'(i), 8'hFE, 8'($urandom), 1'b1, 1'b0, 1'b0);
      mem_access("R2", {4'(i), 12'($urandom)}, 1'b0);
    end
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r = $urandom;
      if (r[1:0] == 2'd0)
        io_cycle(r[7:4], (r[2] ? 8'hFE : r[15:8]), r[23:16], r[24] | r[25], r[26] & r[27], 1'b0);
      else
        mem_access("R5", r[31:16], r[3] & r[2]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule